// File: doc/BRIEF.md
# Burst-Draining FIFO to Serial Transmitter

This block empties an upstream byte FIFO onto a slow asynchronous serial line in whole-buffer bursts. It stays quiet while the FIFO fills. A burst starts when the FIFO signals that it is full. During the burst the block fetches one byte at a time with a one-cycle active-low read strobe and sends that byte as a standard asynchronous character. It keeps fetching until the FIFO signals that it is empty. Because draining starts only at full and stops only at empty, the producer and the consumer take turns in bursts the size of the buffer.

A separate flush input starts a burst even when the FIFO is not full. This empties the last partial buffer at the end of a transfer. The bit period comes from a divider, computed at elaboration as the clock frequency divided by the baud rate and rounded to the nearest integer. The defaults are a 50 MHz clock and 38400 baud, which gives 1302 cycles per bit.

Top module: `fifo_burst_uart_tx`

## Requirements
- R1: While reset is high and in the first cycle after it, `tx` is 1 and `fifo_rd_n` is 1.
- R2: When the block is waiting and `fifo_full_n` is sampled low, `fifo_rd_n` goes low in the next cycle.
- R3: `fifo_rd_n` is low for exactly one cycle per byte, and never while a character is being sent.
- R4: The byte on `fifo_rd_data` is taken at the end of the cycle that follows the strobe. It goes out as one low start bit, then the eight data bits with bit 0 first, then one high stop bit. `tx` idles high.
- R5: Each bit stays on `tx` for DIV cycles, where DIV = round(CLK_HZ / BAUD).
- R6: The empty flag is sampled only in the cycle after a stop bit ends. If `fifo_empty_n` is high, the next strobe follows in the next cycle. If it is low, the block goes back to waiting and issues no more strobes.
- R7: While the block waits, a FIFO that is neither full nor flushed causes no strobe and no activity on `tx`.
- R8: A `flush` pulse while waiting starts a burst when the FIFO is not empty. When the FIFO is empty, the pulse is ignored.
- R9: Once a burst has started, `fifo_full_n` going high does not stop it. Only the empty flag ends the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_full_n | input | 1 | FIFO full flag, active low |
| fifo_empty_n | input | 1 | FIFO empty flag, active low |
| flush | input | 1 | Start a burst without waiting for full |
| fifo_rd_n | output | 1 | Read strobe to the FIFO, active low, one cycle |
| fifo_rd_data | input | 8 | Byte from the FIFO, valid from the cycle after the strobe |
| tx | output | 1 | Serial output, idles high |

## Verification
The assertions assume a well-behaved FIFO: it never raises full and empty together, and it holds `fifo_rd_data` steady from the cycle after a strobe until the byte has been taken. The bench models a four-entry FIFO that updates its flags and data only on falling clock edges. It answers each strobe with exactly one pop, and the producer writes at most one byte per cycle and never writes into a full buffer. A flush is applied only as a single-cycle pulse.

// File: rtl/burst_uart_pkg.sv
package burst_uart_pkg;

  typedef enum logic [1:0] {
    DR_WAIT    = 2'd0,
    DR_STROBE  = 2'd1,
    DR_CAPTURE = 2'd2,
    DR_SEND    = 2'd3
  } drain_state_e;

  function automatic int unsigned round_div(input int unsigned num, input int unsigned den);
    return (num + den / 2) / den;
  endfunction

endpackage

// File: rtl/burst_baud_gen.sv
module burst_baud_gen #(
  parameter int unsigned DIV = 1302
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (run) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && !restart && (cnt == LAST);

endmodule

// File: rtl/burst_uart_ser.sv
module burst_uart_ser #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] data,
  input  logic          tick,
  output logic          tx,
  output logic          busy
);
  localparam int FRAME = DW + 2;
  localparam int IW    = $clog2(FRAME);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME - 1);

  logic [DW:0]   shreg;
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx    <= 1'b1;
      busy  <= 1'b0;
      shreg <= '1;
      idx   <= '0;
    end else if (load && !busy) begin
      tx    <= 1'b0;
      busy  <= 1'b1;
      shreg <= {1'b1, data};
      idx   <= '0;
    end else if (busy && tick) begin
      if (idx == LAST_IDX) begin
        tx   <= 1'b1;
        busy <= 1'b0;
      end else begin
        tx    <= shreg[0];
        shreg <= {1'b1, shreg[DW:1]};
        idx   <= idx + 1'b1;
      end
    end
  end

  // R4: a frame opens with a low start bit
  assert_start_low_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !tx);
  // R4: the line is high once a frame is over
  assert_stop_high_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> tx);
  // R5: the line changes only on a baud tick
  assert_bit_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(tx));

endmodule

// File: rtl/burst_drain_ctl.sv
module burst_drain_ctl
  import burst_uart_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic full_n,
  input  logic empty_n,
  input  logic flush,
  input  logic ser_busy,
  output logic rd_n,
  output logic load
);
  drain_state_e st, nxt;
  logic start;

  assign start = !full_n || (flush && empty_n);

  always_comb begin
    nxt = st;
    unique case (st)
      DR_WAIT:    if (start) nxt = DR_STROBE;
      DR_STROBE:  nxt = DR_CAPTURE;
      DR_CAPTURE: nxt = DR_SEND;
      DR_SEND:    if (!ser_busy) nxt = empty_n ? DR_STROBE : DR_WAIT;
      default:    nxt = DR_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= DR_WAIT;
      rd_n <= 1'b1;
    end else begin
      st   <= nxt;
      rd_n <= (nxt != DR_STROBE);
    end
  end

  assign load = (st == DR_CAPTURE);

  // R3: the strobe lasts one cycle
  assert_rd_single_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_n |=> rd_n);
  // R3: no strobe while a character is going out
  assert_rd_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ser_busy);
  // R7: waiting with no trigger keeps the strobe idle
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (st == DR_WAIT && full_n && !(flush && empty_n)) |=> rd_n);
  // R6: an empty FIFO at frame end returns to waiting
  assert_empty_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (st == DR_SEND && !ser_busy && !empty_n) |=> (rd_n && st == DR_WAIT));

endmodule

// File: rtl/fifo_burst_uart_tx.sv
module fifo_burst_uart_tx #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned BAUD   = 38_400,
  parameter int          DW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_full_n,
  input  logic          fifo_empty_n,
  input  logic          flush,
  output logic          fifo_rd_n,
  input  logic [DW-1:0] fifo_rd_data,
  output logic          tx
);
  localparam int unsigned DIV = burst_uart_pkg::round_div(CLK_HZ, BAUD);

  logic load, busy, tick;

  burst_drain_ctl u_ctl (
    .clk     (clk),
    .rst     (rst),
    .full_n  (fifo_full_n),
    .empty_n (fifo_empty_n),
    .flush   (flush),
    .ser_busy(busy),
    .rd_n    (fifo_rd_n),
    .load    (load)
  );

  burst_baud_gen #(.DIV(DIV)) u_baud (
    .clk    (clk),
    .rst    (rst),
    .restart(load),
    .run    (busy),
    .tick   (tick)
  );

  burst_uart_ser #(.DW(DW)) u_ser (
    .clk (clk),
    .rst (rst),
    .load(load),
    .data(fifo_rd_data),
    .tick(tick),
    .tx  (tx),
    .busy(busy)
  );

  // R2/R9: inputs stay consistent, never full and empty together
  assert_flags_sane_R9: assert property (@(posedge clk) disable iff (rst)
    !(!fifo_full_n && !fifo_empty_n));

endmodule

// File: tb/test_fifo_burst_uart_tx.sv
`timescale 1ns/1ps
module test_fifo_burst_uart_tx;
  localparam int CLK_HZ = 1000;
  localparam int BAUD   = 250;
  localparam int DIV    = 4;
  localparam int FD     = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic full_n = 1'b1, empty_n = 1'b0, flush = 1'b0;
  logic [7:0] rd_data = 8'h00;
  wire rd_n, tx;

  always #2 clk = ~clk;

  fifo_burst_uart_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) i_fifo_burst_uart_tx (
    .clk(clk), .rst(rst), .fifo_full_n(full_n), .fifo_empty_n(empty_n),
    .flush(flush), .fifo_rd_n(rd_n), .fifo_rd_data(rd_data), .tx(tx)
  );

  logic [7:0] fq[$];
  logic [7:0] prod[$];
  int checks = 0, fails = 0, pops = 0, cyc = 0;
  int m_st = 0, m_c = 0;
  logic [7:0] m_byte = 8'h00;
  logic exp_tx = 1'b1, exp_rd = 1'b1;
  logic prev_tx = 1'b1;
  int fall_cyc = 0, first_run = -1;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic frame_bit(input logic [7:0] b, input int i);
    if (i == 0) return 1'b0;
    if (i <= 8) return b[i-1];
    return 1'b1;
  endfunction

  task automatic step(input logic fl, input logic rs);
    @(negedge clk);
    cyc++;
    chk(tx === exp_tx, "R4", "tx line", int'(tx), int'(exp_tx));
    chk(rd_n === exp_rd, "R3", "read strobe", int'(rd_n), int'(exp_rd));
    if (prev_tx === 1'b1 && tx === 1'b0) fall_cyc = cyc;
    if (prev_tx === 1'b0 && tx === 1'b1 && first_run < 0) first_run = cyc - fall_cyc;
    prev_tx = tx;
    flush = fl;
    rst = rs;
    if (rd_n === 1'b0) begin
      chk(fq.size() != 0, "R3", "strobe on empty fifo", 0, 1);
      if (fq.size() != 0) begin
        rd_data = fq.pop_front();
        pops++;
      end
    end
    if (prod.size() != 0 && fq.size() < FD) fq.push_back(prod.pop_front());
    full_n  = !(fq.size() == FD);
    empty_n = (fq.size() != 0);
    if (rst) begin
      m_st = 0; exp_tx = 1'b1; exp_rd = 1'b1;
    end else begin
      case (m_st)
        0: begin
          exp_rd = 1'b1;
          if (!full_n || (flush && empty_n)) begin m_st = 1; exp_rd = 1'b0; end
        end
        1: begin exp_rd = 1'b1; m_st = 2; end
        2: begin m_byte = rd_data; m_c = 0; exp_tx = 1'b0; m_st = 3; end
        3: begin
          m_c++;
          if (m_c == 10*DIV) begin exp_tx = 1'b1; m_st = 4; end
          else exp_tx = frame_bit(m_byte, m_c / DIV);
        end
        default: begin
          if (empty_n) begin m_st = 1; exp_rd = 1'b0; end
          else m_st = 0;
        end
      endcase
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  task automatic run_idle();
    int k;
    k = 0;
    while (!(m_st == 0 && fq.size() == 0 && prod.size() == 0) && k < 3000) begin
      step(1'b0, 1'b0);
      k++;
    end
    chk(k < 3000, "R6", "watchdog waiting for burst end", k, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    int base;
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    chk(tx === 1'b1 && rd_n === 1'b1, "R1", "reset outputs", int'({tx, rd_n}), 3);
    step(1'b0, 1'b0);
    chk(tx === 1'b1 && rd_n === 1'b1, "R1", "first cycle after reset", int'({tx, rd_n}), 3);

    // partial fill: no activity
    prod.push_back(8'hA5); prod.push_back(8'h3C); prod.push_back(8'h00);
    run(60);
    chk(pops == 0, "R7", "pops with partial fill", pops, 0);

    // filling to full starts the burst in the next cycle
    prod.push_back(8'hFF);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk(rd_n === 1'b0, "R2", "strobe one cycle after full", int'(rd_n), 0);
    run_idle();
    chk(pops == 4, "R6", "bytes drained in first burst", pops, 4);
    chk(first_run == DIV, "R5", "start bit length", first_run, DIV);
    run(40);
    chk(pops == 4, "R6", "no strobe after empty", pops, 4);

    // refill during a burst: drain continues past full release
    prod.push_back(8'h12); prod.push_back(8'h80); prod.push_back(8'h7E); prod.push_back(8'h01);
    run(30);
    prod.push_back(8'h55); prod.push_back(8'hC3);
    run_idle();
    chk(pops == 10, "R9", "burst kept going after full released", pops, 10);

    // flush on empty fifo is ignored
    base = pops;
    step(1'b1, 1'b0);
    run(40);
    chk(pops == base, "R8", "flush with empty fifo", pops, base);
    chk(tx === 1'b1, "R8", "line idle after ignored flush", int'(tx), 1);

    // flush drains a partial buffer
    prod.push_back(8'h3C); prod.push_back(8'h81);
    run(4);
    step(1'b1, 1'b0);
    run_idle();
    chk(pops == base + 2, "R8", "flush drained partial buffer", pops, base + 2);
    run(10);
    finish_run();
  end

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog: run did not end actual=%0d expected=0", cyc);
    finish_run();
  end

endmodule